// File: doc/BRIEF.md
# Exception Entry Stacking Sequencer

This block carries out the processor-side entry into an interrupt or exception that has already been accepted by the arbiter. On a start pulse it takes a snapshot of the program counter, the status word, the system stack pointer, the vector table base, the accepted interrupt number and level, and a two-bit class of the instruction that detected the event. It then drives three accesses over a single-port memory interface with a request/ready handshake. The first access reads the handler address from the vector table. The second pushes the status word onto the system stack. The third pushes the return address. Each push lowers the stack pointer by four bytes before it writes.

After the last push, one commit cycle presents the new program counter, the updated status word and the final stack pointer. In the updated status word the level field holds the accepted level and the stack-select bit is cleared. A one-cycle done pulse marks the commit. The surrounding core loads its architectural registers from these outputs when done is high.

Top module: `exc_entry_seq`

## Requirements
- R1: While reset is high and in the first cycle after it is released, busy_o, done_o and mem_req_o are 0, and pc_o, ps_o and ssp_o are all zero.
- R2: A start_i sampled high while idle begins the sequence. The first access is a read (mem_we_o = 0) at address tbr_i + 0x3FC - 4*num_i. Number 0 therefore maps to offset 0x3FC and number 255 maps to offset 0.
- R3: The second access writes the captured ps_i to the captured ssp_i minus 4.
- R4: The third access writes the return address to the captured ssp_i minus 8. The return address is pc_i + 2 for class 2'b00 or 2'b11, pc_i + 4 for class 2'b01, and pc_i + 6 for class 2'b10.
- R5: Each access keeps mem_req_o, mem_we_o, mem_addr_o and mem_wdata_o steady until a clock edge at which mem_ready_i is high. The access completes at that edge, and the next access is presented in the following cycle.
- R6: In the cycle after the commit, the outputs are updated and done_o is high for exactly one cycle. pc_o holds the word read in the first access. ssp_o holds the captured ssp_i minus 8. ps_o is the captured ps_i with bits [20:16] replaced by level_i and bit 5 cleared, and all other bits unchanged. These output values then hold until the next commit.
- R7: A start_i pulse while busy_o is high is ignored. Neither the accesses in flight nor the committed results change.
- R8: busy_o is high from the cycle after an accepted start through the commit cycle, and it is low when done_o is high. No request is made while busy_o is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | Begin an entry sequence (used only when idle) |
| num_i | input | 8 | Accepted interrupt number |
| level_i | input | 5 | Accepted interrupt level |
| iclass_i | input | 2 | Class of the detecting instruction (return step) |
| pc_i | input | 32 | Address of the detecting instruction |
| ps_i | input | 32 | Current status word |
| ssp_i | input | 32 | Current system stack pointer |
| tbr_i | input | 32 | Vector table base |
| mem_req_o | output | 1 | Memory access request |
| mem_we_o | output | 1 | 1 = write, 0 = read |
| mem_addr_o | output | 32 | Memory byte address |
| mem_wdata_o | output | 32 | Write data |
| mem_rdata_i | input | 32 | Read data, valid with mem_ready_i |
| mem_ready_i | input | 1 | Access completes at this edge |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle pulse with the committed results |
| pc_o | output | 32 | Committed handler address |
| ps_o | output | 32 | Committed status word |
| ssp_o | output | 32 | Committed stack pointer |

## Verification
The bench covers vector numbers at both ends of the table. A design that scaled or subtracted the number wrongly would read the wrong table slot. All four class codes are driven, including the unused one, so a wrong return step shows up as a bad value in the second push. Random ready stalls test whether the design holds each request steady: one that advanced without ready, or changed the address mid-stall, would break the expected access order. Start pulses with different operands are also injected mid-sequence. A design that re-captured its inputs on such a pulse would push or commit the values of the second pulse.

// File: rtl/exc_pkg.sv
package exc_pkg;

   typedef enum logic [2:0] {
      ST_IDLE   = 3'd0,
      ST_VEC    = 3'd1,
      ST_PSH_PS = 3'd2,
      ST_PSH_PC = 3'd3,
      ST_COMMIT = 3'd4
   } seq_st_e;

   typedef enum logic [1:0] {
      IC_SHORT = 2'b00,
      IC_MID   = 2'b01,
      IC_LONG  = 2'b10,
      IC_RSVD  = 2'b11
   } iclass_e;

   // byte distance from the detecting instruction to the next one
   function automatic logic [2:0] ret_step(input logic [1:0] cls);
      case (cls)
         IC_MID:  ret_step = 3'd4;
         IC_LONG: ret_step = 3'd6;
         default: ret_step = 3'd2;
      endcase
   endfunction

endpackage

// File: rtl/exc_vec_addr.sv
module exc_vec_addr #(
   parameter int XLEN      = 32,
   parameter int NUM_W     = 8,
   parameter int TBL_BYTES = 1024
) (
   input  logic [XLEN-1:0]  tbr_i,
   input  logic [NUM_W-1:0] num_i,
   output logic [XLEN-1:0]  addr_o
);
   localparam int TOP_OFS = TBL_BYTES - 4;

   logic [XLEN-1:0] slot_ofs;

   always_comb begin
      slot_ofs = XLEN'(TOP_OFS) - (XLEN'(num_i) << 2);
      addr_o   = tbr_i + slot_ofs;
   end
endmodule

// File: rtl/exc_ret_addr.sv
module exc_ret_addr #(
   parameter int XLEN = 32
) (
   input  logic [XLEN-1:0] pc_i,
   input  logic [1:0]      iclass_i,
   output logic [XLEN-1:0] ret_o
);
   import exc_pkg::*;

   always_comb ret_o = pc_i + XLEN'(ret_step(iclass_i));
endmodule

// File: rtl/exc_ps_merge.sv
module exc_ps_merge #(
   parameter int XLEN      = 32,
   parameter int LVL_W     = 5,
   parameter int ILM_LSB   = 16,
   parameter int SFLAG_BIT = 5
) (
   input  logic [XLEN-1:0]  ps_i,
   input  logic [LVL_W-1:0] level_i,
   output logic [XLEN-1:0]  ps_o
);
   for (genvar b = 0; b < XLEN; b++) begin : g_bit
      if (b >= ILM_LSB && b < ILM_LSB + LVL_W) begin : g_lvl
         assign ps_o[b] = level_i[b-ILM_LSB];
      end else if (b == SFLAG_BIT) begin : g_sel
         assign ps_o[b] = 1'b0;
      end else begin : g_keep
         assign ps_o[b] = ps_i[b];
      end
   end
endmodule

// File: rtl/exc_entry_seq.sv
module exc_entry_seq #(
   parameter int XLEN      = 32,
   parameter int NUM_W     = 8,
   parameter int LVL_W     = 5,
   parameter int ILM_LSB   = 16,
   parameter int SFLAG_BIT = 5,
   parameter int TBL_BYTES = 1024
) (
   input  logic             clk_i,
   input  logic             rst_i,
   input  logic             start_i,
   input  logic [NUM_W-1:0] num_i,
   input  logic [LVL_W-1:0] level_i,
   input  logic [1:0]       iclass_i,
   input  logic [XLEN-1:0]  pc_i,
   input  logic [XLEN-1:0]  ps_i,
   input  logic [XLEN-1:0]  ssp_i,
   input  logic [XLEN-1:0]  tbr_i,
   output logic             mem_req_o,
   output logic             mem_we_o,
   output logic [XLEN-1:0]  mem_addr_o,
   output logic [XLEN-1:0]  mem_wdata_o,
   input  logic [XLEN-1:0]  mem_rdata_i,
   input  logic             mem_ready_i,
   output logic             busy_o,
   output logic             done_o,
   output logic [XLEN-1:0]  pc_o,
   output logic [XLEN-1:0]  ps_o,
   output logic [XLEN-1:0]  ssp_o
);
   import exc_pkg::*;

   localparam logic [XLEN-1:0] WORD_B = XLEN'(4);

   initial begin
      if ((4 << NUM_W) > TBL_BYTES)
         $fatal(1, "vector table too small for NUM_W");
      if (ILM_LSB + LVL_W > XLEN)
         $fatal(1, "level field outside status word");
      if (SFLAG_BIT >= XLEN || (SFLAG_BIT >= ILM_LSB && SFLAG_BIT < ILM_LSB + LVL_W))
         $fatal(1, "stack-select bit misplaced");
   end

   seq_st_e          st_q;
   logic [XLEN-1:0]  vec_q, ssp_q, ps_q, ret_q, tmp_q;
   logic [LVL_W-1:0] lvl_q;
   logic [XLEN-1:0]  vec_d, ret_d, ps_new;
   logic [XLEN-1:0]  pc_r, ps_r, sspo_r;
   logic             done_r;
   logic             hs;

   exc_vec_addr #(.XLEN(XLEN), .NUM_W(NUM_W), .TBL_BYTES(TBL_BYTES)) u_vec (
      .tbr_i (tbr_i),
      .num_i (num_i),
      .addr_o(vec_d)
   );

   exc_ret_addr #(.XLEN(XLEN)) u_ret (
      .pc_i    (pc_i),
      .iclass_i(iclass_i),
      .ret_o   (ret_d)
   );

   exc_ps_merge #(.XLEN(XLEN), .LVL_W(LVL_W), .ILM_LSB(ILM_LSB), .SFLAG_BIT(SFLAG_BIT)) u_ps (
      .ps_i   (ps_q),
      .level_i(lvl_q),
      .ps_o   (ps_new)
   );

   always_comb begin
      mem_req_o   = (st_q == ST_VEC) || (st_q == ST_PSH_PS) || (st_q == ST_PSH_PC);
      mem_we_o    = (st_q == ST_PSH_PS) || (st_q == ST_PSH_PC);
      mem_addr_o  = (st_q == ST_VEC) ? vec_q : ssp_q;
      mem_wdata_o = (st_q == ST_PSH_PS) ? ps_q :
                    (st_q == ST_PSH_PC) ? ret_q : '0;
      hs          = mem_req_o && mem_ready_i;
   end

   always_ff @(posedge clk_i) begin
      if (rst_i) begin
         st_q   <= ST_IDLE;
         vec_q  <= '0;
         ssp_q  <= '0;
         ps_q   <= '0;
         ret_q  <= '0;
         tmp_q  <= '0;
         lvl_q  <= '0;
         pc_r   <= '0;
         ps_r   <= '0;
         sspo_r <= '0;
         done_r <= 1'b0;
      end else begin
         done_r <= 1'b0;
         case (st_q)
            ST_IDLE: if (start_i) begin
               vec_q <= vec_d;
               ssp_q <= ssp_i;
               ps_q  <= ps_i;
               ret_q <= ret_d;
               lvl_q <= level_i;
               st_q  <= ST_VEC;
            end
            ST_VEC: if (hs) begin
               tmp_q <= mem_rdata_i;
               ssp_q <= ssp_q - WORD_B;
               st_q  <= ST_PSH_PS;
            end
            ST_PSH_PS: if (hs) begin
               ssp_q <= ssp_q - WORD_B;
               st_q  <= ST_PSH_PC;
            end
            ST_PSH_PC: if (hs) st_q <= ST_COMMIT;
            ST_COMMIT: begin
               pc_r   <= tmp_q;
               ps_r   <= ps_new;
               sspo_r <= ssp_q;
               done_r <= 1'b1;
               st_q   <= ST_IDLE;
            end
            default: st_q <= ST_IDLE;
         endcase
      end
   end

   assign busy_o = (st_q != ST_IDLE);
   assign done_o = done_r;
   assign pc_o   = pc_r;
   assign ps_o   = ps_r;
   assign ssp_o  = sspo_r;
endmodule

// File: rtl/exc_entry_seq_chk.sv
module exc_entry_seq_chk #(
   parameter int XLEN = 32
) (
   input logic            clk_i,
   input logic            rst_i,
   input logic            start_i,
   input logic            busy_o,
   input logic            done_o,
   input logic            mem_req_o,
   input logic            mem_we_o,
   input logic [XLEN-1:0] mem_addr_o,
   input logic [XLEN-1:0] mem_wdata_o,
   input logic            mem_ready_i
);
   logic            wr_hs;
   logic            ps_seen_q;
   logic [XLEN-1:0] ps_slot_q;

   assign wr_hs = mem_req_o && mem_we_o && mem_ready_i;

   always_ff @(posedge clk_i) begin
      if (rst_i) begin
         ps_seen_q <= 1'b0;
         ps_slot_q <= '0;
      end else if (wr_hs) begin
         ps_seen_q <= !ps_seen_q;
         ps_slot_q <= mem_addr_o;
      end
   end

   // R6
   done_pulse_chk: assert property (@(posedge clk_i) disable iff (rst_i)
      done_o |=> !done_o);

   // R6
   done_idle_chk: assert property (@(posedge clk_i) disable iff (rst_i)
      done_o |-> !busy_o);

   // R5
   req_hold_chk: assert property (@(posedge clk_i) disable iff (rst_i)
      (mem_req_o && !mem_ready_i) |=> (mem_req_o && $stable(mem_addr_o)
                                       && $stable(mem_we_o) && $stable(mem_wdata_o)));

   // R8
   idle_no_req_chk: assert property (@(posedge clk_i) disable iff (rst_i)
      !busy_o |-> !mem_req_o);

   // R8
   busy_cause_chk: assert property (@(posedge clk_i) disable iff (rst_i)
      $rose(busy_o) |-> $past(start_i));

   // R4
   push_order_chk: assert property (@(posedge clk_i) disable iff (rst_i)
      (wr_hs && ps_seen_q) |-> (mem_addr_o == ps_slot_q - XLEN'(4)));
endmodule

bind exc_entry_seq exc_entry_seq_chk #(.XLEN(XLEN)) u_chk (
   .clk_i      (clk_i),
   .rst_i      (rst_i),
   .start_i    (start_i),
   .busy_o     (busy_o),
   .done_o     (done_o),
   .mem_req_o  (mem_req_o),
   .mem_we_o   (mem_we_o),
   .mem_addr_o (mem_addr_o),
   .mem_wdata_o(mem_wdata_o),
   .mem_ready_i(mem_ready_i)
);

// File: tb/sim_exc_entry_seq.sv
`timescale 1ns/1ps
module sim_exc_entry_seq;
   logic        clk = 1'b0;
   logic        rst_i = 1'b1;
   logic        start_i = 1'b0;
   logic [7:0]  num_i = '0;
   logic [4:0]  level_i = '0;
   logic [1:0]  iclass_i = '0;
   logic [31:0] pc_i = '0, ps_i = '0, ssp_i = '0, tbr_i = '0;
   logic        mem_req_o, mem_we_o, busy_o, done_o;
   logic [31:0] mem_addr_o, mem_wdata_o, pc_o, ps_o, ssp_o;
   logic [31:0] mem_rdata_i = '0;
   logic        mem_ready_i = 1'b0;

   always #2 clk = ~clk;

   exc_entry_seq u0 (
      .clk_i(clk), .rst_i(rst_i), .start_i(start_i), .num_i(num_i),
      .level_i(level_i), .iclass_i(iclass_i), .pc_i(pc_i), .ps_i(ps_i),
      .ssp_i(ssp_i), .tbr_i(tbr_i), .mem_req_o(mem_req_o), .mem_we_o(mem_we_o),
      .mem_addr_o(mem_addr_o), .mem_wdata_o(mem_wdata_o), .mem_rdata_i(mem_rdata_i),
      .mem_ready_i(mem_ready_i), .busy_o(busy_o), .done_o(done_o),
      .pc_o(pc_o), .ps_o(ps_o), .ssp_o(ssp_o)
   );

   int vecs = 0;
   int bad  = 0;

   // reference model state
   int          ph = 0;
   bit          e_done = 0;
   logic [31:0] e_pc = 0, e_ps = 0, e_ssp = 0;
   logic [31:0] m_vec, m_ssp, m_ps, m_ret, m_hnd;
   logic [4:0]  m_lvl;
   logic [31:0] lf = 32'h1234_5678;
   bit          stall = 0;

   task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
      vecs++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s: actual %h expected %h at %0t", r, act, exp, $time);
      end
   endtask

   function automatic logic [31:0] step_of(input logic [1:0] c);
      if (c == 2'b01) return 32'd4;
      if (c == 2'b10) return 32'd6;
      return 32'd2;
   endfunction

   task automatic step(input bit st);
      @(negedge clk);
      chk("R8 busy", {31'b0, busy_o}, {31'b0, ph != 0});
      chk("R5 req", {31'b0, mem_req_o}, {31'b0, ph >= 1 && ph <= 3});
      chk("R6 done", {31'b0, done_o}, {31'b0, e_done});
      if (ph == 1) begin
         chk("R2 rd", {31'b0, mem_we_o}, 32'd0);
         chk("R2 vaddr", mem_addr_o, m_vec);
      end
      if (ph == 2) begin
         chk("R3 we", {31'b0, mem_we_o}, 32'd1);
         chk("R3 addr", mem_addr_o, m_ssp - 32'd4);
         chk("R3 data", mem_wdata_o, m_ps);
      end
      if (ph == 3) begin
         chk("R4 we", {31'b0, mem_we_o}, 32'd1);
         chk("R4 addr", mem_addr_o, m_ssp - 32'd8);
         chk("R4 data", mem_wdata_o, m_ret);
      end
      chk("R6 pc", pc_o, e_pc);
      chk("R6 ps", ps_o, e_ps);
      chk("R6 ssp", ssp_o, e_ssp);
      // drive next inputs
      start_i = st;
      lf = lf * 32'd1103515245 + 32'd12345;
      mem_ready_i = stall ? lf[17] : 1'b1;
      mem_rdata_i = (ph == 1) ? m_hnd : lf;
      // advance model to after the coming edge
      e_done = 0;
      if (ph == 0) begin
         if (st) begin
            m_vec = tbr_i + 32'h3FC - 32'(num_i) * 4;
            m_ssp = ssp_i;
            m_ps  = ps_i;
            m_ret = pc_i + step_of(iclass_i);
            m_lvl = level_i;
            ph = 1;
         end
      end else if (ph <= 3) begin
         if (mem_ready_i) ph++;
      end else begin
         e_pc  = m_hnd;
         e_ps  = m_ps;
         e_ps[20:16] = m_lvl;
         e_ps[5] = 1'b0;
         e_ssp = m_ssp - 32'd8;
         e_done = 1;
         ph = 0;
      end
   endtask

   task automatic run(input logic [7:0] n, input logic [4:0] l, input logic [1:0] c,
                      input logic [31:0] pc, input logic [31:0] ps, input logic [31:0] sp,
                      input logic [31:0] tb, input logic [31:0] hnd, input bit stl,
                      input bit poke);
      num_i = n; level_i = l; iclass_i = c; pc_i = pc; ps_i = ps; ssp_i = sp; tbr_i = tb;
      m_hnd = hnd; stall = stl;
      step(1'b1);
      for (int k = 0; k < 400 && (ph != 0 || e_done); k++) begin
         if (poke && (k % 3 == 1)) begin
            // R7: different operands with start while busy
            num_i = ~n; level_i = ~l; iclass_i = ~c; pc_i = ~pc; ps_i = ~ps;
            ssp_i = sp + 32'h100; tbr_i = ~tb;
            step(1'b1);
         end else begin
            step(1'b0);
         end
      end
      step(1'b0);
      step(1'b0);
   endtask

   initial begin
      #400000;
      bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1 reset state
      chk("R1 busy", {31'b0, busy_o}, 32'd0);
      chk("R1 req", {31'b0, mem_req_o}, 32'd0);
      chk("R1 done", {31'b0, done_o}, 32'd0);
      chk("R1 pc", pc_o, 32'd0);
      chk("R1 ps", ps_o, 32'd0);
      chk("R1 ssp", ssp_o, 32'd0);
      rst_i = 1'b0;
      step(1'b0);
      // R2 number 0 at top slot, class 00 -> +2
      run(8'd0,   5'd4,  2'b00, 32'h0000_1000, 32'h0000_0020, 32'h0000_8000, 32'h000F_FC00, 32'hAAAA_0001, 0, 0);
      // R2 number 255 at offset 0, class 01 -> +4
      run(8'd255, 5'd31, 2'b01, 32'h0000_2002, 32'hFFFF_FFFF, 32'h0000_4000, 32'h0001_0000, 32'hBBBB_0002, 0, 0);
      // R4 class 10 -> +6 with stalls (R5)
      run(8'd17,  5'd9,  2'b10, 32'h1234_5670, 32'h0001_0021, 32'h0000_7F00, 32'h2000_0000, 32'hCCCC_0003, 1, 0);
      // R4 class 11 -> +2 with stalls
      run(8'd128, 5'd0,  2'b11, 32'hFFFF_FFFE, 32'h801F_0000, 32'h0000_0004, 32'h0000_0400, 32'hDDDD_0004, 1, 0);
      // R7 starts while busy are ignored
      run(8'd63,  5'd15, 2'b01, 32'h0000_3000, 32'h5A5A_A5A5, 32'h0000_9000, 32'h0004_0000, 32'hEEEE_0005, 1, 1);
      run(8'd1,   5'd2,  2'b10, 32'h0000_0100, 32'h0000_FFFF, 32'h0000_A000, 32'h0000_0000, 32'h1111_0006, 0, 1);
      for (int i = 0; i < 6; i++)
         run(8'(i * 41), 5'(i * 7), 2'(i), 32'h40 * i, 32'h1357_9BDF ^ i,
             32'h0001_0000 - 32'h40 * i, 32'h0010_0000, 32'h7000_0000 + i, 1, i[0]);
      $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
      $finish;
   end
endmodule